// File: doc/BRIEF.md
# Adder-Based Four-Bit Arithmetic-Logic Unit

This block is a purely combinational arithmetic-logic unit. It takes two operands, `opX` and `opY`, and a four-bit function code `funcSel`. It returns a result word and a carry-out. Every arithmetic function is produced by one ripple-carry adder. The adder's second input is always `opX`. Its carry-in is select bit 0. Its first input comes from per-bit conditioning logic, `a_i = (sel2 & ~y_i) | (sel1 & y_i)`, which yields all-zeros, `opY`, `~opY` or all-ones.

Beside the adder, a bitwise logic unit computes one of four word-wide functions. Both units evaluate all the time. Select bit 3 drives a final multiplexer that passes one of the two results and discards the other. The width is a parameter with a default of 4. The function encoding below is fixed.

Top module: `alu4_core`

## Requirements
- R1: With `funcSel` = 4'b0000 the result equals `opX` and the carry is 0. With `funcSel` = 4'b0111 the result equals `opX` and the carry is 1, because `opX` + all-ones + 1 wraps.
- R2: `funcSel` = 4'b0001 gives `opX`+1, with carry 1 only when `opX` is all-ones. `funcSel` = 4'b0110 gives `opX`-1, with carry 1 whenever `opX` is nonzero.
- R3: `funcSel` = 4'b0010 gives `opX`+`opY`, and `funcSel` = 4'b0011 gives `opX`+`opY`+1. In both cases the carry is bit WIDTH of the exact sum.
- R4: `funcSel` = 4'b0101 gives the two's-complement difference `opX`-`opY`, with carry 1 exactly when `opX` >= `opY` (unsigned).
- R5: `funcSel` = 4'b0100 gives the ones'-complement difference `opX`+`~opY`, with carry 1 exactly when `opX` > `opY` (unsigned).
- R6: With `funcSel[3]` = 1, `funcSel[1:0]` selects the logic function: 00 gives AND, 01 gives OR, 10 gives XOR, and 11 gives NOT `opX`.
- R7: With `funcSel[3]` = 1, `funcSel[2]` has no effect on the result.
- R8: With `funcSel[3]` = 1, `carryOut` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opX | input | WIDTH | First operand; always the adder's second input |
| opY | input | WIDTH | Second operand; conditioned before entering the adder |
| funcSel | input | 4 | Function code; bit 3 picks logic (1) or arithmetic (0) |
| result | output | WIDTH | Selected unit's result |
| carryOut | output | 1 | Adder carry for arithmetic codes; 0 for logic codes |

## Verification
The assertions assume that inputs are stable when they are evaluated and that they hold no X or Z bits. They relate the result to the operands by arithmetic on the whole word, not by the gate-level conditioning. The bench drives only known values. It changes the inputs once per cycle, just after a rising edge, and compares at the falling edge, after the combinational paths have settled. Every one of the 4096 operand and code combinations is applied, so the codes with select bit 2 set in logic mode, the wrap of the all-ones code, and equal or extreme operands are all covered.

// File: rtl/alu4_pkg.sv
package alu4_pkg;

  // Logic-unit function, encoded as funcSel[1:0]
  typedef enum logic [1:0] {
    LOG_AND  = 2'b00,
    LOG_OR   = 2'b01,
    LOG_XOR  = 2'b10,
    LOG_NOTX = 2'b11
  } logicOp_e;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic     padInvert;  // feed ~Y bits into the adder's first input
    logic     padPass;    // feed Y bits into the adder's first input
    logic     carryIn;    // adder carry-in
    logicOp_e logicOp;    // bitwise function
    logic     pickLogic;  // output mux: 1 = logic unit
  } aluCtrl_t;

endpackage

// File: rtl/alu4_ctrl.sv
module alu4_ctrl
  import alu4_pkg::*;
(
  input  logic [3:0] funcSel,
  output aluCtrl_t   ctrl
);

  always_comb begin
    ctrl.padInvert = funcSel[2];
    ctrl.padPass   = funcSel[1];
    ctrl.carryIn   = funcSel[0];
    ctrl.logicOp   = logicOp_e'(funcSel[1:0]);
    ctrl.pickLogic = funcSel[3];
  end

endmodule

// File: rtl/alu4_full_adder.sv
module alu4_full_adder (
  input  logic a,
  input  logic b,
  input  logic cin,
  output logic sum,
  output logic cout
);

  logic halfSum;

  assign halfSum = a ^ b;
  assign sum     = halfSum ^ cin;
  assign cout    = (a & b) | (halfSum & cin);

endmodule

// File: rtl/alu4_datapath.sv
module alu4_datapath
  import alu4_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  aluCtrl_t         ctrl,
  input  logic [WIDTH-1:0] opX,
  input  logic [WIDTH-1:0] opY,
  output logic [WIDTH-1:0] result,
  output logic             carryOut
);

  logic [WIDTH-1:0] adderA;
  logic [WIDTH-1:0] arithSum;
  logic [WIDTH-1:0] logicOut;
  logic [WIDTH:0]   carryChain;

  assign carryChain[0] = ctrl.carryIn;

  // Input conditioning and ripple chain, one stage per bit
  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    assign adderA[i] = (ctrl.padInvert & ~opY[i]) | (ctrl.padPass & opY[i]);

    alu4_full_adder fa_i (
      .a    (adderA[i]),
      .b    (opX[i]),
      .cin  (carryChain[i]),
      .sum  (arithSum[i]),
      .cout (carryChain[i+1])
    );
  end

  // Bitwise logic unit, always active
  always_comb begin
    unique case (ctrl.logicOp)
      LOG_AND:  logicOut = opX & opY;
      LOG_OR:   logicOut = opX | opY;
      LOG_XOR:  logicOut = opX ^ opY;
      LOG_NOTX: logicOut = ~opX;
      default:  logicOut = '0;
    endcase
  end

  // Output steering
  assign result   = ctrl.pickLogic ? logicOut : arithSum;
  assign carryOut = ctrl.pickLogic ? 1'b0 : carryChain[WIDTH];

endmodule

// File: rtl/alu4_core.sv
module alu4_core
  import alu4_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] opX,
  input  logic [WIDTH-1:0] opY,
  input  logic [3:0]       funcSel,
  output logic [WIDTH-1:0] result,
  output logic             carryOut
);

  aluCtrl_t ctrl;

  alu4_ctrl ctrl_i (
    .funcSel (funcSel),
    .ctrl    (ctrl)
  );

  alu4_datapath #(.WIDTH(WIDTH)) dp_i (
    .ctrl     (ctrl),
    .opX      (opX),
    .opY      (opY),
    .result   (result),
    .carryOut (carryOut)
  );

endmodule

// File: rtl/alu4_core_checker.sv
module alu4_core_checker #(
  parameter int WIDTH = 4
) (
  input logic [WIDTH-1:0] opX,
  input logic [WIDTH-1:0] opY,
  input logic [3:0]       funcSel,
  input logic [WIDTH-1:0] result,
  input logic             carryOut
);

  logic [WIDTH-1:0] ones;
  logic [WIDTH-1:0] diff;
  logic [WIDTH-1:0] incr;

  assign ones = '1;
  assign diff = opX - opY;
  assign incr = opX + 1'b1;

  always_comb begin
    if (funcSel == 4'b0000) begin
      p_transfer_r1: assert (result == opX && !carryOut)
        else $error("transfer code mismatch");
    end
    if (funcSel == 4'b0111) begin
      p_wrap_r1: assert (result == opX && carryOut)
        else $error("wrap code mismatch");
    end
    if (funcSel == 4'b0001) begin
      p_inc_r2: assert (result == incr && carryOut == (opX == ones))
        else $error("increment mismatch");
    end
    if (funcSel == 4'b0101) begin
      p_sub_r4: assert (result == diff && carryOut == (opX >= opY))
        else $error("subtract mismatch");
    end
    if (funcSel[3] && funcSel[1:0] == 2'b11) begin
      p_notx_r6: assert (result == ~opX)
        else $error("complement mismatch");
    end
    if (funcSel[3]) begin
      p_logic_nocarry_r8: assert (!carryOut)
        else $error("carry in logic mode");
    end
  end

endmodule

bind alu4_core alu4_core_checker #(.WIDTH(WIDTH)) chk_i (
  .opX      (opX),
  .opY      (opY),
  .funcSel  (funcSel),
  .result   (result),
  .carryOut (carryOut)
);

// File: tb/alu4_core_tb_top.sv
module alu4_core_tb_top;

  localparam int W = 4;

  typedef struct {
    logic [W-1:0] expResult;
    logic         expCarry;
    string        tag;
    logic [3:0]   sel;
    logic [W-1:0] x;
    logic [W-1:0] y;
  } sbItem_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] opX = '0;
  logic [W-1:0] opY = '0;
  logic [3:0]   funcSel = '0;
  logic [W-1:0] result;
  logic         carryOut;

  int      testsRun  = 0;
  int      testsFail = 0;
  int      cycles    = 0;
  bit      finished  = 1'b0;
  sbItem_t sbQueue[$];

  always #4 clk = ~clk;  // 125 MHz

  alu4_core #(.WIDTH(W)) dut_i (
    .opX      (opX),
    .opY      (opY),
    .funcSel  (funcSel),
    .result   (result),
    .carryOut (carryOut)
  );

  // Reference model: {carry, result} from the function definitions
  function automatic logic [W:0] refModel(input logic [3:0] s,
                                           input logic [W-1:0] x,
                                           input logic [W-1:0] y);
    logic [W:0]   wide;
    logic [W-1:0] nx;
    nx = ~y;
    if (s[3]) begin
      unique case (s[1:0])
        2'b00:   wide = {1'b0, x & y};
        2'b01:   wide = {1'b0, x | y};
        2'b10:   wide = {1'b0, x ^ y};
        default: wide = {1'b0, ~x};
      endcase
    end else begin
      unique case (s[2:0])
        3'd0:    wide = {1'b0, x};
        3'd1:    wide = {(x == {W{1'b1}}), W'(x + 1'b1)};
        3'd2:    wide = (W+1)'(x) + (W+1)'(y);
        3'd3:    wide = (W+1)'(x) + (W+1)'(y) + 1'b1;
        3'd4:    wide = {(x > y), W'(x + nx)};
        3'd5:    wide = {(x >= y), W'(x - y)};
        3'd6:    wide = {(x != '0), W'(x - 1'b1)};
        default: wide = {1'b1, x};
      endcase
    end
    return wide;
  endfunction

  function automatic string reqTag(input logic [3:0] s);
    if (s[3]) return s[2] ? "R7/R8" : "R6/R8";
    case (s[2:0])
      3'd0, 3'd7: return "R1";
      3'd1, 3'd6: return "R2";
      3'd2, 3'd3: return "R3";
      3'd5:       return "R4";
      default:    return "R5";
    endcase
  endfunction

  // Driver: apply one vector and push its expectation
  task automatic applyVec(input logic [3:0] s, input logic [W-1:0] x,
                          input logic [W-1:0] y, input string tag);
    sbItem_t    it;
    logic [W:0] e;
    @(posedge clk);
    #1;
    opX = x;
    opY = y;
    funcSel = s;
    e = refModel(s, x, y);
    it.expResult = e[W-1:0];
    it.expCarry  = e[W];
    it.tag = tag;
    it.sel = s;
    it.x = x;
    it.y = y;
    sbQueue.push_back(it);
  endtask

  // Monitor: compare settled outputs mid-cycle
  always @(negedge clk) begin
    if (!rst && sbQueue.size() > 0) begin
      sbItem_t it;
      it = sbQueue.pop_front();
      testsRun++;
      if (result !== it.expResult || carryOut !== it.expCarry) begin
        testsFail++;
        $display("FAIL %s sel=%b x=%h y=%h: actual g=%h c=%b expected g=%h c=%b",
                 it.tag, it.sel, it.x, it.y, result, carryOut,
                 it.expResult, it.expCarry);
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1'b1;
      testsFail++;
      $display("FAIL watchdog: actual cycles=%0d expected completion", cycles);
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // Reset state: zero operands, transfer code gives zero (R1)
    applyVec(4'b0000, '0, '0, "R1 reset");
    // Boundary cases called out by the requirements
    applyVec(4'b0111, 4'hF, 4'h3, "R1 wrap");
    applyVec(4'b0001, 4'hF, 4'h0, "R2 inc overflow");
    applyVec(4'b0110, 4'h0, 4'h0, "R2 dec underflow");
    applyVec(4'b0101, 4'h6, 4'h6, "R4 equal");
    applyVec(4'b0100, 4'h6, 4'h6, "R5 equal");
    applyVec(4'b1110, 4'hA, 4'h3, "R7 sel2 set");
    applyVec(4'b1011, 4'hA, 4'h3, "R6 not");
    // Exhaustive sweep over every code and operand pair
    for (int s = 0; s < 16; s++) begin
      for (int x = 0; x < 16; x++) begin
        for (int y = 0; y < 16; y++) begin
          applyVec(4'(s), 4'(x), 4'(y), reqTag(4'(s)));
        end
      end
    end
    @(posedge clk);
    while (sbQueue.size() > 0) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFail);
      $finish;
    end
  end

endmodule